// File: doc/BRIEF.md
# Bit Interleave and Deinterleave Unit

This unit rearranges bits between a 32-bit word and a pair of 16-bit halfwords. It interleaves two halfwords into one word so that their bits alternate, in the ordering used for Morton (Z-order) indexing. It also does the reverse, separating a word's even-position and odd-position bits into two halfwords. Two single-operand modes cover a common pin-mapping task. The first spreads one halfword onto every second bit of a word, on either the even or the odd lane. The second squishes one lane of a word back into a halfword.

An operation is presented with `in_valid`. The result appears on `result` one clock later, flagged by `out_valid`. The result register loads only on valid cycles and otherwise keeps its value.

Top module: `bitlace_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released with no valid input, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. A valid input's result is on `result` in that same cycle.
- R3: When `in_valid` is 0, `result` keeps its previous value.
- R4: Merge (`op_sel` = 0): `result[2i+1]` = `opnd_a[i]` and `result[2i]` = `opnd_b[i]` for i = 0..15.
- R5: Split (`op_sel` = 1): `result[16+i]` = `opnd_a[2i+1]` (odd bits) and `result[i]` = `opnd_a[2i]` (even bits).
- R6: Splitting a merged word returns the two original halfwords, with `opnd_a` in the upper half and `opnd_b` in the lower half.
- R7: Spread (`op_sel` = 2) with `odd_lane` = 0: `result[2i]` = `opnd_a[i]` and all odd bits are 0. For example, 0b11001 gives 0b0101000001.
- R8: Spread with `odd_lane` = 1: `result[2i+1]` = `opnd_a[i]` and all even bits are 0.
- R9: Squish (`op_sel` = 3): `result[i]` = `opnd_a[2i + odd_lane]` and `result[31:16]` is 0.
- R10: Spreading a halfword and then squishing the result with the same `odd_lane` returns the halfword.
- R11: `odd_lane` has no effect on merge or split.
- R12: `opnd_a[31:16]` has no effect on merge or spread, and `opnd_b` has no effect on split, spread or squish.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 2 | 0 merge, 1 split, 2 spread, 3 squish |
| odd_lane | input | 1 | Lane select for spread and squish: 1 odd, 0 even |
| opnd_a | input | 32 | Word operand; its low 16 bits are the halfword for merge and spread |
| opnd_b | input | 16 | Second halfword for merge |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |

## Verification
The assertions assume that `in_valid` is low during reset and in the cycle reset is released. They also assume that `op_sel` carries one of the four defined codes whenever `in_valid` is high. The stimulus holds `in_valid` at 0 until after reset and draws `op_sel` only from 0 to 3. The bit-count and lane-mask properties look only at the inputs of the cycle before a valid output. The stimulus therefore mixes idle cycles with back-to-back operations, so that both held and freshly loaded results are seen.

// File: rtl/bitlace_pkg.sv
package bitlace_pkg;
  typedef enum logic [1:0] {
    LACE_MERGE  = 2'd0,
    LACE_SPLIT  = 2'd1,
    LACE_SPREAD = 2'd2,
    LACE_SQUISH = 2'd3
  } lace_op_e;
endpackage

// File: rtl/bitlace_dilate.sv
// Places each bit of a narrow value on the even positions of a word twice as wide.
module bitlace_dilate #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   narrow,
  output logic [2*HALF_W-1:0] wide
);
  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    assign wide[2*i]   = narrow[i];
    assign wide[2*i+1] = 1'b0;
  end
endmodule

// File: rtl/bitlace_gather.sv
// Separates a wide word into its even-position and odd-position bits.
module bitlace_gather #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] wide,
  output logic [HALF_W-1:0]   even_bits,
  output logic [HALF_W-1:0]   odd_bits
);
  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    assign even_bits[i] = wide[2*i];
    assign odd_bits[i]  = wide[2*i+1];
  end
endmodule

// File: rtl/bitlace_outreg.sv
// Output stage: the valid flag follows the input, and the data loads only on valid cycles.
module bitlace_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      q       <= q_nxt;
    end
  end
endmodule

// File: rtl/bitlace_unit.sv
module bitlace_unit #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op_sel,
  input  logic                odd_lane,
  input  logic [2*HALF_W-1:0] opnd_a,
  input  logic [HALF_W-1:0]   opnd_b,
  output logic                out_valid,
  output logic [2*HALF_W-1:0] result
);
  import bitlace_pkg::*;

  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] dil_a, dil_b;
  logic [HALF_W-1:0] evn_a, odd_a;
  logic [FULL_W-1:0] res_nxt;
  lace_op_e          op;

  assign op = lace_op_e'(op_sel);

  bitlace_dilate #(.HALF_W(HALF_W)) u_dil_a (.narrow(opnd_a[HALF_W-1:0]), .wide(dil_a));
  bitlace_dilate #(.HALF_W(HALF_W)) u_dil_b (.narrow(opnd_b), .wide(dil_b));
  bitlace_gather #(.HALF_W(HALF_W)) u_gat (.wide(opnd_a), .even_bits(evn_a), .odd_bits(odd_a));

  always_comb begin
    res_nxt = '0;
    unique case (op)
      LACE_MERGE:  res_nxt = (dil_a << 1) | dil_b;
      LACE_SPLIT:  res_nxt = {odd_a, evn_a};
      LACE_SPREAD: res_nxt = odd_lane ? (dil_a << 1) : dil_a;
      LACE_SQUISH: res_nxt = {{HALF_W{1'b0}}, (odd_lane ? odd_a : evn_a)};
      default:     res_nxt = '0;
    endcase
  end

  bitlace_outreg #(.W(FULL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .d(res_nxt),
    .q_valid(out_valid), .q(result)
  );
endmodule

// File: rtl/bitlace_chk.sv
module bitlace_chk #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          op_sel,
  input logic                odd_lane,
  input logic [2*HALF_W-1:0] opnd_a,
  input logic [HALF_W-1:0]   opnd_b,
  input logic                out_valid,
  input logic [2*HALF_W-1:0] result
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] even_mask, odd_mask;
  always_comb begin
    even_mask = '0;
    odd_mask  = '0;
    for (int i = 0; i < HALF_W; i++) begin
      even_mask[2*i]   = 1'b1;
      odd_mask[2*i+1]  = 1'b1;
    end
  end

  // R1: reset holds the output idle
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R2: valid follows the input by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: no load without a request
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R4: merge keeps every set bit of both halfwords
  a_r4_merge_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd0) |=>
      $countones(result) == $countones($past(opnd_a[HALF_W-1:0])) + $countones($past(opnd_b)));

  // R5: split is a permutation of the word
  a_r5_split_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd1) |=> $countones(result) == $countones($past(opnd_a)));

  // R7: even-lane spread leaves odd positions clear
  a_r7_spread_even: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2 && !odd_lane) |=> (result & odd_mask) == '0);

  // R8: odd-lane spread leaves even positions clear
  a_r8_spread_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2 && odd_lane) |=> (result & even_mask) == '0);

  // R9: squish upper half is zero
  a_r9_squish_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd3) |=> result[FULL_W-1:HALF_W] == '0);

  // R7/R8: spread keeps the bit count of the halfword
  a_r7_spread_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2) |=> $countones(result) == $countones($past(opnd_a[HALF_W-1:0])));
endmodule

bind bitlace_unit bitlace_chk #(.HALF_W(HALF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .odd_lane(odd_lane), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .out_valid(out_valid), .result(result)
);

// File: tb/bitlace_unit_tb.sv
`timescale 1ns/1ps
module bitlace_unit_tb_top;
  localparam int H = 16;
  localparam int F = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   op_sel;
  logic         odd_lane;
  logic [F-1:0] opnd_a;
  logic [H-1:0] opnd_b;
  logic         out_valid;
  logic [F-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic         exp_valid;
  logic [F-1:0] exp_res;

  always #2 clk = ~clk;

  bitlace_unit #(.HALF_W(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .odd_lane(odd_lane), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [F-1:0] ref_calc(int op, bit odd, logic [F-1:0] a, logic [H-1:0] b);
    logic [F-1:0] r;
    r = '0;
    for (int i = 0; i < H; i++) begin
      case (op)
        0: begin r[2*i+1] = a[i]; r[2*i] = b[i]; end
        1: begin r[H+i] = a[2*i+1]; r[i] = a[2*i]; end
        2: r[2*i + (odd ? 1 : 0)] = a[i];
        default: r[i] = a[2*i + (odd ? 1 : 0)];
      endcase
    end
    return r;
  endfunction

  task automatic check_eq(string tag, logic [F-1:0] act, logic [F-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(string tag, bit v, int op, bit odd, logic [F-1:0] a, logic [H-1:0] b);
    in_valid = v; op_sel = op[1:0]; odd_lane = odd; opnd_a = a; opnd_b = b;
    exp_valid = v;
    if (v) exp_res = ref_calc(op, odd, a, b);
    @(posedge clk);
    @(negedge clk);
    check_eq({tag, " valid"}, {31'd0, out_valid}, {31'd0, exp_valid});
    check_eq(tag, result, exp_res);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [H-1:0] h, g;
    logic [F-1:0] w;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 2'd0; odd_lane = 1'b0;
    opnd_a = '0; opnd_b = '0;
    exp_valid = 1'b0; exp_res = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check_eq("R1 reset result", result, 32'd0);
    rst_n = 1'b1;
    step("R1 idle after reset", 0, 0, 0, 32'hFFFF_FFFF, 16'hFFFF);

    // R7: example from the requirement
    step("R7 spread example", 1, 2, 0, 32'h0000_0019, 16'h0);
    check_eq("R7 spread literal", result, 32'b0101000001);
    // R8: odd lane
    step("R8 spread odd", 1, 2, 1, 32'h0000_0019, 16'h0);
    check_eq("R8 spread odd literal", result, 32'b1010000010);
    // R3: hold over idle cycles
    step("R3 hold", 0, 0, 0, 32'h1234_5678, 16'hABCD);
    step("R3 hold again", 0, 3, 1, 32'hDEAD_BEEF, 16'h5555);
    // R4: merge corners
    step("R4 merge a ones", 1, 0, 0, 32'h0000_FFFF, 16'h0000);
    check_eq("R4 merge odd positions", result, 32'hAAAA_AAAA);
    step("R4 merge b ones", 1, 0, 0, 32'h0000_0000, 16'hFFFF);
    check_eq("R4 merge even positions", result, 32'h5555_5555);
    // R12: upper bits of opnd_a ignored by merge and spread
    step("R12 merge upper ignored", 1, 0, 0, 32'hFFFF_0000, 16'h0000);
    check_eq("R12 merge zero", result, 32'h0);
    step("R12 spread upper ignored", 1, 2, 1, 32'hFFFF_0001, 16'hFFFF);
    check_eq("R12 spread single", result, 32'h2);
    // R5: split corners
    step("R5 split", 1, 1, 0, 32'hAAAA_AAAA, 16'h0);
    check_eq("R5 split odd to top", result, 32'hFFFF_0000);
    // R11: lane select ignored by split and merge
    step("R11 split odd_lane", 1, 1, 1, 32'h5555_5555, 16'h1234);
    check_eq("R11 split value", result, 32'h0000_FFFF);
    step("R11 merge odd_lane", 1, 0, 1, 32'h0000_FFFF, 16'h0000);
    check_eq("R11 merge value", result, 32'hAAAA_AAAA);
    // R9: squish both lanes
    step("R9 squish even", 1, 3, 0, 32'h5555_5555, 16'hFFFF);
    check_eq("R9 squish even value", result, 32'h0000_FFFF);
    step("R9 squish odd", 1, 3, 1, 32'h5555_5555, 16'hFFFF);
    check_eq("R9 squish odd value", result, 32'h0);

    // R2: back-to-back random mix against the model
    for (int k = 0; k < 300; k++) begin
      int  op;
      bit  v;
      op = $urandom_range(0, 3);
      v  = ($urandom_range(0, 3) != 0);
      step(op == 0 ? "R2 R4 random merge" : op == 1 ? "R2 R5 random split" :
           op == 2 ? "R2 R7 random spread" : "R2 R9 random squish",
           v, op, $urandom_range(0, 1), $urandom, $urandom);
    end

    // R10: spread then squish with the same lane returns the halfword
    for (int k = 0; k < 60; k++) begin
      bit odd;
      h = $urandom; odd = $urandom_range(0, 1);
      step("R10 spread", 1, 2, odd, {16'h0, h}, 16'h0);
      w = result;
      step("R10 squish", 1, 3, odd, w, $urandom);
      check_eq("R10 round trip", result, {16'h0, h});
    end

    // R6: merge then split returns both halfwords
    for (int k = 0; k < 60; k++) begin
      h = $urandom; g = $urandom;
      step("R6 merge", 1, 0, 0, {$urandom_range(0, 65535), h}, g);
      w = result;
      step("R6 split", 1, 1, 0, w, $urandom);
      check_eq("R6 round trip", result, {h, g});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule